// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target side of a four-wire serial programming link for a small microcontroller-style memory model. An external host drives a serial clock and a data line into the block and reads a data line back. The block runs on its own CPU clock and oversamples the serial clock. A phase filter rejects serial-clock phases that are too short to count. On each accepted rising serial edge one host bit is shifted in. On each accepted falling edge the return bit moves on.

Every instruction is a 32-bit frame made of four bytes, most significant bit first. The first byte is an opcode, the second and third form an address (high byte first), and the fourth carries data. A host first sends the enable instruction. It can tell that it is bit-aligned because the enable key it sent as the second byte comes back while it sends the third. After that, the block accepts chip erase and byte reads and writes on a program array and an EEPROM array. Each erase or write starts a self-timed busy window, and no further erase or write is accepted until that window ends. The active-high reset pin returns the block to its unsynchronised state.

Top module: `isp_slave`

## Requirements
- R1: MOSI is captured on each accepted rising SCK edge, MSB first. Every frame is exactly 32 bits and is decoded after its 32nd accepted rising edge. It is laid out as opcode [31:24], address high [23:16], address low [15:8], data [7:0]. All four bytes are consumed whatever their content.
- R2: MISO changes only after an accepted falling SCK edge. The second outgoing byte of every frame repeats the first incoming byte, and the third outgoing byte repeats the second incoming byte. The first outgoing byte is 0x00.
- R3: A frame with opcode 0xAC and second byte 0x53 sets the synced output. A frame with opcode 0xAC and any other second byte leaves synced low. synced rises only when a frame completes.
- R4: While synced is low, every frame other than the enable frame has no effect: no erase, no write, and the fourth outgoing byte of a read is 0x00.
- R5: A level on SCK counts only once it has held for more than THR CPU clocks after synchronisation. THR is 3 when the CLK_HZ parameter is at least 12000000, and 2 otherwise. Shorter pulses are ignored.
- R6: Opcode 0xAC with second byte 0x80 (chip erase) sets every byte of both arrays to 0xFF.
- R7: Opcode 0x40 writes the data byte to the program array, and opcode 0xC0 writes it to the EEPROM array. An EEPROM write replaces the stored byte outright, with no prior erase.
- R8: Opcode 0x20 (program) or 0xA0 (EEPROM) returns the addressed byte as the fourth outgoing byte. Only the low address bits that index the array are used, so addresses wrap modulo the depth.
- R9: An accepted erase or write raises busy for BUSY_CYC CPU clocks. An erase or write frame that completes while busy is high is ignored.
- R10: While rst_pin is high, synced, busy and the bit counter clear and MISO goes to 0. A frame started after the pulse is aligned from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock that oversamples the serial lines |
| rst_pin | input | 1 | Active-high reset; a pulse unsynchronises the block |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| synced | output | 1 | High once an enable frame with the correct key has completed |
| busy | output | 1 | High during the self-timed window after an erase or write |

## Verification
The frame engine is driven with several kinds of frames: enable frames with the right and the wrong key, writes and reads to both arrays, chip erase, and reads past the array depth. The returned bytes show whether the echo path selects the right incoming byte and whether reads index the right array with the right address bits. Repeated writes to one EEPROM byte tell a true replace apart from a bitwise merge. Writes and erases sent during a busy window show whether the hold-off works. Short high pulses of three and five CPU clocks on SCK, each followed by an enable frame, show from the resulting sync state where the phase filter draws its line. A frame cut short by a reset pulse checks that the bit counter realigns.

// File: rtl/isp_pkg.sv
package isp_pkg;

   localparam int FRAME_BYTES = 4;
   localparam int FAST_HZ     = 12_000_000;

   localparam logic [7:0] OP_CTRL    = 8'hAC;
   localparam logic [7:0] KEY_ENABLE = 8'h53;
   localparam logic [7:0] KEY_ERASE  = 8'h80;
   localparam logic [7:0] OP_RD_PROG = 8'h20;
   localparam logic [7:0] OP_WR_PROG = 8'h40;
   localparam logic [7:0] OP_RD_EE   = 8'hA0;
   localparam logic [7:0] OP_WR_EE   = 8'hC0;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ENABLE,
      CMD_ERASE,
      CMD_WR_PROG,
      CMD_WR_EE
   } cmd_e;

   function automatic int phase_limit(input int hz);
      return (hz >= FAST_HZ) ? 3 : 2;
   endfunction

   function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] b1);
      cmd_e c;
      c = CMD_NONE;
      if (op == OP_CTRL && b1 == KEY_ENABLE) c = CMD_ENABLE;
      else if (op == OP_CTRL && b1 == KEY_ERASE) c = CMD_ERASE;
      else if (op == OP_WR_PROG) c = CMD_WR_PROG;
      else if (op == OP_WR_EE) c = CMD_WR_EE;
      return c;
   endfunction

endpackage

// File: rtl/isp_sck_filter.sv
module isp_sck_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int THR         = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic sck,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic mosi_s
);
   localparam int CW = $clog2(THR + 1);

   logic [SYNC_STAGES-1:0] sck_sy;
   logic [SYNC_STAGES-1:0] mosi_sy;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) begin
                  sck_sy[0]  <= 1'b0;
                  mosi_sy[0] <= 1'b0;
               end else begin
                  sck_sy[0]  <= sck;
                  mosi_sy[0] <= mosi;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) begin
                  sck_sy[g]  <= 1'b0;
                  mosi_sy[g] <= 1'b0;
               end else begin
                  sck_sy[g]  <= sck_sy[g-1];
                  mosi_sy[g] <= mosi_sy[g-1];
               end
            end
         end
      end
   endgenerate

   logic          sck_raw;
   logic          lvl_q;
   logic [CW-1:0] run_q;

   assign sck_raw = sck_sy[SYNC_STAGES-1];
   assign mosi_s  = mosi_sy[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q    <= 1'b0;
         run_q    <= '0;
         sck_rise <= 1'b0;
         sck_fall <= 1'b0;
      end else begin
         sck_rise <= 1'b0;
         sck_fall <= 1'b0;
         if (sck_raw != lvl_q) begin
            if (run_q == CW'(THR)) begin
               lvl_q    <= sck_raw;
               run_q    <= '0;
               sck_rise <= sck_raw;
               sck_fall <= ~sck_raw;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

endmodule

// File: rtl/isp_frame.sv
module isp_frame
   import isp_pkg::*;
#(
   parameter int NBYTES = FRAME_BYTES
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          sck_rise,
   input  logic                          sck_fall,
   input  logic                          mosi_s,
   input  logic [7:0]                    tx_byte,
   output logic [$clog2(NBYTES*8)-1:0]   bit_cnt,
   output logic [NBYTES*8-1:0]           word,
   output logic                          frame_done,
   output logic                          miso
);
   localparam int NB = NBYTES * 8;
   localparam int CW = $clog2(NB);

   logic [7:0] tx_q;
   logic       pend_q;

   assign miso = tx_q[7];

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt    <= '0;
         word       <= '0;
         frame_done <= 1'b0;
         pend_q     <= 1'b0;
         tx_q       <= '0;
      end else begin
         frame_done <= 1'b0;
         if (sck_rise) begin
            word    <= {word[NB-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt[2:0] == 3'd7) pend_q <= 1'b1;
            if (bit_cnt == CW'(NB - 1)) frame_done <= 1'b1;
         end
         if (sck_fall) begin
            if (pend_q) begin
               tx_q   <= tx_byte;
               pend_q <= 1'b0;
            end else begin
               tx_q <= {tx_q[6:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
   parameter int PROG_DEPTH = 64,
   parameter int EE_DEPTH   = 32,
   parameter int BUSY_CYC   = 1000
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          erase,
   input  logic                          wr_prog,
   input  logic                          wr_ee,
   input  logic [$clog2(PROG_DEPTH)-1:0] wa_prog,
   input  logic [$clog2(EE_DEPTH)-1:0]   wa_ee,
   input  logic [7:0]                    wdata,
   input  logic                          rd_ee,
   input  logic [$clog2(PROG_DEPTH)-1:0] ra_prog,
   input  logic [$clog2(EE_DEPTH)-1:0]   ra_ee,
   output logic [7:0]                    rdata,
   output logic                          busy
);
   localparam int BW = $clog2(BUSY_CYC + 1);

   logic [7:0]    prog_q [PROG_DEPTH];
   logic [7:0]    ee_q   [EE_DEPTH];
   logic [BW-1:0] wait_q;

   always_ff @(posedge clk) begin
      if (erase) begin
         for (int i = 0; i < PROG_DEPTH; i++) prog_q[i] <= 8'hFF;
         for (int j = 0; j < EE_DEPTH; j++)   ee_q[j]   <= 8'hFF;
      end else begin
         if (wr_prog) prog_q[wa_prog] <= wdata;
         if (wr_ee)   ee_q[wa_ee]     <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wait_q <= '0;
      end else if (erase || wr_prog || wr_ee) begin
         wait_q <= BW'(BUSY_CYC);
      end else if (wait_q != '0) begin
         wait_q <= wait_q - 1'b1;
      end
   end

   assign busy  = (wait_q != '0);
   assign rdata = rd_ee ? ee_q[ra_ee] : prog_q[ra_prog];

endmodule

// File: rtl/isp_slave.sv
module isp_slave
   import isp_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int PROG_DEPTH  = 64,
   parameter int EE_DEPTH    = 32,
   parameter int BUSY_CYC    = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_pin,
   input  logic sck,
   input  logic mosi,
   output logic miso,
   output logic synced,
   output logic busy
);
   localparam int THR = phase_limit(CLK_HZ);
   localparam int PW  = $clog2(PROG_DEPTH);
   localparam int EW  = $clog2(EE_DEPTH);
   localparam int NB  = FRAME_BYTES * 8;
   localparam int CW  = $clog2(NB);

   generate
      if (PROG_DEPTH < 2 || (PROG_DEPTH & (PROG_DEPTH - 1)) != 0 || PROG_DEPTH > 256)
         $error("PROG_DEPTH must be a power of two from 2 to 256");
      if (EE_DEPTH < 2 || (EE_DEPTH & (EE_DEPTH - 1)) != 0 || EE_DEPTH > 256)
         $error("EE_DEPTH must be a power of two from 2 to 256");
      if (BUSY_CYC < 1) $error("BUSY_CYC must be at least 1");
      if (SYNC_STAGES < 1) $error("SYNC_STAGES must be at least 1");
      if (CLK_HZ < 1) $error("CLK_HZ must be positive");
   endgenerate

   logic          sck_rise, sck_fall, mosi_s;
   logic [CW-1:0] bit_cnt;
   logic [NB-1:0] word;
   logic          frame_done;
   logic [7:0]    tx_byte;
   logic [7:0]    rdata;
   logic          synced_q;
   logic          wr_go;
   cmd_e          cmd;
   logic          unused_hi;

   isp_sck_filter #(.SYNC_STAGES(SYNC_STAGES), .THR(THR)) u_filt (
      .clk(clk), .rst(rst_pin), .sck(sck), .mosi(mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
   );

   isp_frame #(.NBYTES(FRAME_BYTES)) u_frame (
      .clk(clk), .rst(rst_pin), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .mosi_s(mosi_s), .tx_byte(tx_byte), .bit_cnt(bit_cnt), .word(word),
      .frame_done(frame_done), .miso(miso)
   );

   assign cmd   = decode_cmd(word[31:24], word[23:16]);
   assign wr_go = frame_done && synced_q && !busy &&
                  (cmd == CMD_ERASE || cmd == CMD_WR_PROG || cmd == CMD_WR_EE);

   isp_mem #(.PROG_DEPTH(PROG_DEPTH), .EE_DEPTH(EE_DEPTH), .BUSY_CYC(BUSY_CYC)) u_mem (
      .clk(clk), .rst(rst_pin),
      .erase(wr_go && cmd == CMD_ERASE),
      .wr_prog(wr_go && cmd == CMD_WR_PROG),
      .wr_ee(wr_go && cmd == CMD_WR_EE),
      .wa_prog(word[8 +: PW]), .wa_ee(word[8 +: EW]), .wdata(word[7:0]),
      .rd_ee(word[23:16] == OP_RD_EE),
      .ra_prog(word[PW-1:0]), .ra_ee(word[EW-1:0]),
      .rdata(rdata), .busy(busy)
   );

   // Outgoing byte, chosen just after a byte boundary (word then holds
   // the bytes received so far, the latest in word[7:0]).
   always_comb begin
      case (bit_cnt[CW-1:3])
         2'd1, 2'd2: tx_byte = word[7:0];
         2'd3: tx_byte = (synced_q && (word[23:16] == OP_RD_PROG ||
                                       word[23:16] == OP_RD_EE)) ? rdata : 8'h00;
         default: tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst_pin) synced_q <= 1'b0;
      else if (frame_done && cmd == CMD_ENABLE) synced_q <= 1'b1;
   end

   assign synced    = synced_q;
   assign unused_hi = ^word[15:8];

endmodule

// File: rtl/isp_slave_chk.sv
module isp_slave_chk (
   input logic       clk,
   input logic       rst_pin,
   input logic       sck_fall,
   input logic       miso,
   input logic       frame_done,
   input logic       synced,
   input logic       wr_go,
   input logic       busy,
   input logic [4:0] bit_cnt
);
   // R2
   miso_hold_chk: assert property (@(posedge clk) disable iff (rst_pin)
      !sck_fall |=> $stable(miso));

   // R3
   sync_on_frame_chk: assert property (@(posedge clk) disable iff (rst_pin)
      (!frame_done && !synced) |=> !synced);

   // R9
   busy_after_write_chk: assert property (@(posedge clk) disable iff (rst_pin)
      wr_go |=> busy);

   // R4
   no_write_unsynced_chk: assert property (@(posedge clk) disable iff (rst_pin)
      !synced |-> !wr_go);

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst_pin |=> (bit_cnt == 5'd0 && !synced && !miso && !busy));
endmodule

bind isp_slave isp_slave_chk u_chk (
   .clk(clk), .rst_pin(rst_pin), .sck_fall(sck_fall), .miso(miso),
   .frame_done(frame_done), .synced(synced), .wr_go(wr_go), .busy(busy),
   .bit_cnt(bit_cnt)
);

// File: tb/isp_slave_bench.sv
module isp_slave_bench;
   localparam int BUSY = 2000;
   localparam int H    = 12;

   logic clk = 1'b0;
   logic rst_pin = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic miso, synced, busy;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   isp_slave #(.CLK_HZ(50_000_000), .PROG_DEPTH(64), .EE_DEPTH(32),
               .BUSY_CYC(BUSY), .SYNC_STAGES(2)) u_isp_slave (
      .clk(clk), .rst_pin(rst_pin), .sck(sck), .mosi(mosi),
      .miso(miso), .synced(synced), .busy(busy)
   );

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] tx, output logic [31:0] rx);
      for (int i = 31; i >= 0; i--) begin
         mosi = tx[i];
         tick(H);
         rx[i] = miso;
         sck = 1'b1;
         tick(H);
         sck = 1'b0;
      end
      tick(20);
   endtask

   task automatic pulse_reset();
      rst_pin = 1'b1;
      tick(4);
      rst_pin = 1'b0;
      tick(4);
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 3 * BUSY && busy; k++) tick(1);
   endtask

   logic [31:0] r;

   task automatic t_reset();
      chk("R10 miso after reset", {31'd0, miso}, 32'd0);
      chk("R10 synced after reset", {31'd0, synced}, 32'd0);
      chk("R10 busy after reset", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_wrong_key();
      xfer(32'hAC54_0000, r);
      chk("R3 wrong key leaves unsynced", {31'd0, synced}, 32'd0);
      chk("R2 third byte echoes second", {24'd0, r[15:8]}, 32'h54);
   endtask

   task automatic t_enable();
      xfer(32'hAC53_1234, r);
      chk("R3 enable sets synced", {31'd0, synced}, 32'd1);
      chk("R2 enable echo bytes", {8'd0, r[31:8]}, 32'h0000AC53);
   endtask

   task automatic t_erase();
      xfer(32'hAC80_0000, r);
      chk("R9 busy after erase", {31'd0, busy}, 32'd1);
      wait_idle();
      xfer(32'h2000_0000, r);
      chk("R6 program byte 0 erased", {24'd0, r[7:0]}, 32'hFF);
      xfer(32'h2000_3F00, r);
      chk("R6 program last byte erased", {24'd0, r[7:0]}, 32'hFF);
      xfer(32'hA000_0000, r);
      chk("R6 eeprom byte 0 erased", {24'd0, r[7:0]}, 32'hFF);
      xfer(32'hA000_1F00, r);
      chk("R6 eeprom last byte erased", {24'd0, r[7:0]}, 32'hFF);
   endtask

   task automatic t_write_read();
      int c;
      xfer(32'h4000_0A5A, r);
      c = 0;
      while (busy && c < 3 * BUSY) begin
         tick(1);
         c++;
      end
      total++;
      if (c < BUSY - 60 || c > BUSY) begin
         bad++;
         $display("FAIL R9 busy length actual=%0d expected=%0d", c, BUSY);
      end
      xfer(32'h2000_0A00, r);
      chk("R7 R8 program write then read", {24'd0, r[7:0]}, 32'h5A);
      xfer(32'hC000_023C, r);
      wait_idle();
      xfer(32'hA000_0200, r);
      chk("R7 R8 eeprom write then read", {24'd0, r[7:0]}, 32'h3C);
      xfer(32'h2000_4A00, r);
      chk("R8 address wraps modulo depth", {24'd0, r[7:0]}, 32'h5A);
      xfer(32'hA000_0A00, r);
      chk("R8 eeprom and program kept apart", {24'd0, r[7:0]}, 32'hFF);
   endtask

   task automatic t_ee_replace();
      xfer(32'hC000_04AA, r);
      wait_idle();
      xfer(32'hC000_0455, r);
      wait_idle();
      xfer(32'hA000_0400, r);
      chk("R7 eeprom overwrite without erase", {24'd0, r[7:0]}, 32'h55);
   endtask

   task automatic t_busy_block();
      xfer(32'h4000_0B11, r);
      xfer(32'h4000_0B22, r);
      wait_idle();
      xfer(32'h2000_0B00, r);
      chk("R9 write while busy ignored", {24'd0, r[7:0]}, 32'h11);
      xfer(32'h4000_0C33, r);
      xfer(32'hAC80_0000, r);
      wait_idle();
      xfer(32'h2000_0C00, r);
      chk("R9 erase while busy ignored", {24'd0, r[7:0]}, 32'h33);
   endtask

   task automatic t_unsynced();
      pulse_reset();
      chk("R10 reset pulse unsyncs", {31'd0, synced}, 32'd0);
      xfer(32'h4000_0A77, r);
      chk("R4 write unsynced ignored busy", {31'd0, busy}, 32'd0);
      xfer(32'h2000_0A00, r);
      chk("R4 read unsynced returns zero", {24'd0, r[7:0]}, 32'h00);
      xfer(32'hAC53_0000, r);
      xfer(32'h2000_0A00, r);
      chk("R4 R1 data kept after unsynced write", {24'd0, r[7:0]}, 32'h5A);
   endtask

   task automatic t_midframe_reset();
      for (int i = 0; i < 10; i++) begin
         mosi = 1'b1;
         tick(H);
         sck = 1'b1;
         tick(H);
         sck = 1'b0;
      end
      tick(H);
      pulse_reset();
      chk("R10 miso cleared by reset", {31'd0, miso}, 32'd0);
      xfer(32'hAC53_0000, r);
      chk("R10 R1 realigned after reset", {31'd0, synced}, 32'd1);
      chk("R1 R2 echo after realign", {16'd0, r[23:8]}, 32'h0000AC53);
   endtask

   task automatic t_filter();
      pulse_reset();
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
      tick(20);
      xfer(32'hAC53_0000, r);
      chk("R5 three-clock pulse ignored", {31'd0, synced}, 32'd1);
      pulse_reset();
      sck = 1'b1;
      tick(5);
      sck = 1'b0;
      tick(20);
      xfer(32'hAC53_0000, r);
      chk("R5 five-clock pulse counted", {31'd0, synced}, 32'd0);
   endtask

   initial begin
      tick(5);
      rst_pin = 1'b0;
      tick(2);
      t_reset();
      t_wrong_key();
      t_enable();
      t_erase();
      t_write_read();
      t_ee_replace();
      t_busy_block();
      t_unsynced();
      t_midframe_reset();
      t_filter();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule